// File: doc/BRIEF.md
# Three-Phase Motor Output Emergency Cutoff Controller

This block sits between the PWM generator of a three-phase motor timer and the six drive pins: three phases, each with a true leg and an inverted leg. It guards those pins with an active-low shutdown input. The shutdown input is assumed to be already synchronised and filtered.

The block owns a motor-output enable flag. It also owns a small control register, which software can write only while an external protect bit is open. When shutdown goes low, the enable flag is cleared. A cutoff-enable field in the register then decides what the pins do:

- If cutoff is enabled, all six pins are released to high impedance in the same cycle.
- If cutoff is not enabled, the pins fall back to general-purpose port data and direction.

The high-impedance state is sticky. It ends only once shutdown is high again and the cutoff-enable field reads 0.

The control register also carries these fields, which the block presents to neighbouring logic:

- two A/D-trigger mode bits, one for each of two timers;
- an interrupt-source select bit;
- a reload-timing select bit. This bit is masked to 0 while the three-phase mode-0 flag or triangular-modulation mode is active.

Top module: `motor_cutoff_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the enable flag is 0, and the pins follow port data and port direction.
- R2: A register write takes effect on the next clock edge only when the protect bit is 1. With the protect bit at 0 the stored value is unchanged.
- R3: The register bit positions are fixed. Bit0 is reload-timing select, bit1 is cutoff enable, bit2 is the timer-0 A/D-trigger mode, bit3 is the timer-1 A/D-trigger mode, and bit4 is interrupt-source select. Bits 5 to 7 always read 0, whatever is written to them.
- R4: The outputs `adtrig0_mode`, `adtrig1_mode` and `irq_src_sel` equal register bits 2, 3 and 4.
- R5: `reload_sel_eff` equals register bit0, except that it is 0 whenever `mode0_active` or `tri_mod_active` is 1.
- R6: The enable flag loads `ena_wdata` on `ena_wr`. A low shutdown clears it on the next edge, and this clear takes priority over a write in the same cycle.
- R7: With the enable flag at 1, shutdown high and no cutoff active, `pin_out` equals `pwm_in` and every `pin_oe` bit is 1.
- R8: With cutoff enable at 1 and shutdown low, `pin_oe` and `pin_out` are all 0 in that same cycle, before any clock edge.
- R9: With no cutoff active, and either the enable flag at 0 or shutdown low, `pin_out` equals `port_dout` and `pin_oe` equals `port_dir`.
- R10: Once entered, high impedance persists until a clock edge at which shutdown is high and cutoff enable is 0. It persists through clearing cutoff enable while shutdown is still low, and through shutdown returning high while cutoff enable stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_open | input | 1 | Protect bit; register writes are accepted only when 1 |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| ena_wr | input | 1 | Enable flag write strobe |
| ena_wdata | input | 1 | Enable flag write value |
| ena_flag | output | 1 | Motor-output enable flag |
| shutdown_n | input | 1 | Active-low shutdown request |
| mode0_active | input | 1 | Three-phase mode-0 flag |
| tri_mod_active | input | 1 | Triangular-modulation mode flag |
| reload_sel_eff | output | 1 | Effective reload-timing select |
| adtrig0_mode | output | 1 | Timer-0 A/D-trigger mode |
| adtrig1_mode | output | 1 | Timer-1 A/D-trigger mode |
| irq_src_sel | output | 1 | Interrupt-source select |
| pwm_in | input | 6 | PWM levels for the six pins |
| port_dout | input | 6 | General-purpose port data |
| port_dir | input | 6 | General-purpose port direction (1 = drive) |
| pin_out | output | 6 | Pin output levels |
| pin_oe | output | 6 | Pin output enables (0 = high impedance) |

## Verification
The pin multiplexer is exercised in four situations:

- Running with the enable flag set, which separates PWM pass-through from port fallback.
- Shutdown with cutoff disabled, where pins must track port data and direction rather than PWM. This covers both the cycle before the flag clears and the cycles after it.
- Shutdown with cutoff enabled, where all-zero enables distinguish high impedance from fallback in the very cycle that shutdown is seen.
- Recovery orderings: cutoff enable cleared while shutdown is still low, shutdown released while cutoff enable stays 1, and a blocked write attempt. These show whether exit from high impedance needs both conditions rather than just one.

Distinct PWM, port-data and port-direction patterns are used so that any wrong source selection shows up at the pins.

// File: rtl/mcut_pkg.sv
`timescale 1ns/1ps
package mcut_pkg;
  localparam int CTRL_W   = 8;
  localparam int LIVE_W   = 5;
  localparam int F_RELOAD = 0;
  localparam int F_CUT    = 1;
  localparam int F_ADT0   = 2;
  localparam int F_ADT1   = 3;
  localparam int F_IRQ    = 4;

  typedef struct packed {
    logic irq_src;
    logic adt1;
    logic adt0;
    logic cut_en;
    logic reload;
  } ctrl_t;

  typedef enum logic [1:0] {DRV_PORT = 2'd0, DRV_PWM = 2'd1, DRV_HIZ = 2'd2} drive_e;

  // Read view: live fields at the bottom, everything above reads zero.
  function automatic logic [CTRL_W-1:0] read_view(input ctrl_t c);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[LIVE_W-1:0] = c;
    return r;
  endfunction

  // Extract the live fields from a write word; reserved and unassigned bits dropped.
  function automatic ctrl_t write_view(input logic [CTRL_W-1:0] w);
    return ctrl_t'(w[LIVE_W-1:0]);
  endfunction

  // Reload select is masked by either mode flag.
  function automatic logic reload_mask(input logic sel, input logic m0, input logic tri_m);
    return sel & ~m0 & ~tri_m;
  endfunction

  // Sticky high-impedance state: set on shutdown with cutoff enabled,
  // released only when shutdown is high and cutoff is disabled.
  function automatic logic hiz_next(input logic cur, input logic cut, input logic sd_n);
    logic n;
    n = cur;
    if (!sd_n && cut)      n = 1'b1;
    else if (sd_n && !cut) n = 1'b0;
    return n;
  endfunction

  function automatic drive_e pick_drive(input logic cutoff, input logic ena, input logic sd_n);
    drive_e d;
    if (cutoff)          d = DRV_HIZ;
    else if (ena && sd_n) d = DRV_PWM;
    else                 d = DRV_PORT;
    return d;
  endfunction
endpackage

// File: rtl/mcut_ctrl_reg.sv
`timescale 1ns/1ps
module mcut_ctrl_reg
  import mcut_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prot_open,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output ctrl_t        fields
);
  ctrl_t q;
  logic  wr_accept;

  assign wr_accept = wr & prot_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (wr_accept) q <= write_view(wdata[CTRL_W-1:0]);
  end

  assign fields = q;
  assign rdata  = W'(read_view(q));
endmodule

// File: rtl/mcut_hold.sv
`timescale 1ns/1ps
module mcut_hold
  import mcut_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shutdown_n,
  input  logic   cut_en,
  input  logic   ena_wr,
  input  logic   ena_wdata,
  output logic   ena_q,
  output logic   cutoff_active,
  output drive_e drive
);
  logic hiz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ena_q <= 1'b0;
    else if (!shutdown_n) ena_q <= 1'b0;
    else if (ena_wr)      ena_q <= ena_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hiz_q <= 1'b0;
    else        hiz_q <= hiz_next(hiz_q, cut_en, shutdown_n);
  end

  assign cutoff_active = hiz_q | (cut_en & ~shutdown_n);
  assign drive         = pick_drive(cutoff_active, ena_q, shutdown_n);
endmodule

// File: rtl/mcut_pin_mux.sv
`timescale 1ns/1ps
module mcut_pin_mux
  import mcut_pkg::*;
#(
  parameter int N = 6
) (
  input  drive_e       drive,
  input  logic [N-1:0] pwm_in,
  input  logic [N-1:0] port_dout,
  input  logic [N-1:0] port_dir,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      unique case (drive)
        DRV_PWM: begin pin_out[i] = pwm_in[i];    pin_oe[i] = 1'b1;        end
        DRV_HIZ: begin pin_out[i] = 1'b0;         pin_oe[i] = 1'b0;        end
        default: begin pin_out[i] = port_dout[i]; pin_oe[i] = port_dir[i]; end
      endcase
    end
  end
endmodule

// File: rtl/motor_cutoff_ctrl.sv
`timescale 1ns/1ps
module motor_cutoff_ctrl
  import mcut_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int REG_W    = CTRL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prot_open,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                ena_wr,
  input  logic                ena_wdata,
  output logic                ena_flag,
  input  logic                shutdown_n,
  input  logic                mode0_active,
  input  logic                tri_mod_active,
  output logic                reload_sel_eff,
  output logic                adtrig0_mode,
  output logic                adtrig1_mode,
  output logic                irq_src_sel,
  input  logic [NUM_PINS-1:0] pwm_in,
  input  logic [NUM_PINS-1:0] port_dout,
  input  logic [NUM_PINS-1:0] port_dir,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  ctrl_t  fields;
  drive_e drive;
  logic   cutoff_active;

  mcut_ctrl_reg #(.W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .prot_open(prot_open), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .fields(fields)
  );

  mcut_hold u_hold (
    .clk(clk), .rst_n(rst_n), .shutdown_n(shutdown_n), .cut_en(fields.cut_en),
    .ena_wr(ena_wr), .ena_wdata(ena_wdata), .ena_q(ena_flag),
    .cutoff_active(cutoff_active), .drive(drive)
  );

  mcut_pin_mux #(.N(NUM_PINS)) u_mux (
    .drive(drive), .pwm_in(pwm_in), .port_dout(port_dout), .port_dir(port_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign reload_sel_eff = reload_mask(fields.reload, mode0_active, tri_mod_active);
  assign adtrig0_mode   = fields.adt0;
  assign adtrig1_mode   = fields.adt1;
  assign irq_src_sel    = fields.irq_src;
endmodule

// File: rtl/motor_cutoff_ctrl_chk.sv
`timescale 1ns/1ps
module motor_cutoff_ctrl_chk #(
  parameter int NUM_PINS = 6,
  parameter int REG_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                prot_open,
  input logic                reg_wr,
  input logic [REG_W-1:0]    reg_rdata,
  input logic                ena_flag,
  input logic                shutdown_n,
  input logic                mode0_active,
  input logic                tri_mod_active,
  input logic                reload_sel_eff,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                cutoff_active
);
  // R2
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !prot_open) |=> $stable(reg_rdata));
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:5] == '0);
  // R5
  reload_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0_active || tri_mod_active) |-> !reload_sel_eff);
  // R6
  ena_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_n |=> !ena_flag);
  // R8
  hiz_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff_active |-> (pin_oe == '0 && pin_out == '0));
  // R10
  hiz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cutoff_active && !(shutdown_n && reg_rdata[1] == 1'b0)) |=> cutoff_active);
endmodule

bind motor_cutoff_ctrl motor_cutoff_ctrl_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prot_open(prot_open), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .ena_flag(ena_flag), .shutdown_n(shutdown_n),
  .mode0_active(mode0_active), .tri_mod_active(tri_mod_active),
  .reload_sel_eff(reload_sel_eff), .pin_oe(pin_oe), .pin_out(pin_out),
  .cutoff_active(cutoff_active)
);

// File: tb/motor_cutoff_ctrl_test.sv
`timescale 1ns/1ps
module motor_cutoff_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int NVEC = 8;
  // {protect, write data, expected read value}
  localparam logic [16:0] REG_VEC [NVEC] = '{
    {1'b1, 8'hFF, 8'h1F}, {1'b0, 8'h00, 8'h1F}, {1'b1, 8'h05, 8'h05},
    {1'b1, 8'hE0, 8'h00}, {1'b0, 8'h1A, 8'h00}, {1'b1, 8'h1A, 8'h1A},
    {1'b1, 8'h80, 8'h00}, {1'b1, 8'h00, 8'h00}};

  logic clk = 0, rst_n = 0;
  logic prot_open = 0, reg_wr = 0, ena_wr = 0, ena_wdata = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ena_flag, shutdown_n = 1, mode0_active = 0, tri_mod_active = 0;
  logic reload_sel_eff, adtrig0_mode, adtrig1_mode, irq_src_sel;
  logic [NP-1:0] pwm_in = 6'b101100, port_dout = 6'b010011, port_dir = 6'b110001;
  logic [NP-1:0] pin_out, pin_oe;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_cutoff_ctrl uut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic prot, input logic [7:0] d);
    prot_open = prot; reg_wr = 1; reg_wdata = d;
    tick();
    reg_wr = 0; prot_open = 0;
  endtask

  task automatic wr_ena(input logic v);
    ena_wr = 1; ena_wdata = v;
    tick();
    ena_wr = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    #1; tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    chk("R1 rdata", {8'h0, reg_rdata}, 16'h0);
    chk("R1 ena", {15'h0, ena_flag}, 16'h0);
    chk("R1 out", {10'h0, pin_out}, {10'h0, port_dout});
    chk("R1 oe", {10'h0, pin_oe}, {10'h0, port_dir});

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr_reg(REG_VEC[i][16], REG_VEC[i][15:8]);
      chk("R2/R3 rdata", {8'h0, reg_rdata}, {8'h0, REG_VEC[i][7:0]});
      chk("R4 fields", {13'h0, irq_src_sel, adtrig1_mode, adtrig0_mode},
          {13'h0, REG_VEC[i][4], REG_VEC[i][3], REG_VEC[i][2]});
      chk("R5 reload", {15'h0, reload_sel_eff}, {15'h0, REG_VEC[i][0]});
    end

    // R5 masking
    wr_reg(1, 8'h01);
    mode0_active = 1; #1;
    chk("R5 mode0 mask", {15'h0, reload_sel_eff}, 16'h0);
    mode0_active = 0; tri_mod_active = 1; #1;
    chk("R5 tri mask", {15'h0, reload_sel_eff}, 16'h0);
    tri_mod_active = 0; #1;
    chk("R5 unmasked", {15'h0, reload_sel_eff}, 16'h1);
    wr_reg(1, 8'h00);

    // R7 run mode
    wr_ena(1);
    chk("R6 ena set", {15'h0, ena_flag}, 16'h1);
    chk("R7 pwm", {10'h0, pin_out}, {10'h0, pwm_in});
    chk("R7 oe", {10'h0, pin_oe}, 16'h003F);
    pwm_in = 6'b010011; #1;
    chk("R7 pwm2", {10'h0, pin_out}, 16'h0013);

    // R9 shutdown with cutoff disabled: port fallback in same cycle
    shutdown_n = 0; #1;
    chk("R9 fallback out", {10'h0, pin_out}, {10'h0, port_dout});
    chk("R9 fallback oe", {10'h0, pin_oe}, {10'h0, port_dir});
    ena_wr = 1; ena_wdata = 1; tick(); ena_wr = 0;
    chk("R6 clear wins", {15'h0, ena_flag}, 16'h0);
    shutdown_n = 1; tick();
    chk("R9 ena off", {10'h0, pin_out}, {10'h0, port_dout});
    chk("R9 ena off oe", {10'h0, pin_oe}, {10'h0, port_dir});

    // R8 cutoff enabled
    wr_reg(1, 8'h02);
    wr_ena(1);
    chk("R7 before cut", {10'h0, pin_oe}, 16'h003F);
    shutdown_n = 0; #1;
    chk("R8 oe same cycle", {10'h0, pin_oe}, 16'h0);
    chk("R8 out same cycle", {10'h0, pin_out}, 16'h0);
    tick();
    chk("R6 ena cleared", {15'h0, ena_flag}, 16'h0);

    // R10 stickiness
    shutdown_n = 1; tick(); tick();
    chk("R10 sd high cut 1", {10'h0, pin_oe}, 16'h0);
    wr_reg(0, 8'h00);
    chk("R10 blocked clear", {10'h0, pin_oe}, 16'h0);
    shutdown_n = 0;
    wr_reg(1, 8'h00);
    chk("R10 cut 0 sd low", {10'h0, pin_oe}, 16'h0);
    tick();
    chk("R10 still hiz", {10'h0, pin_out | pin_oe}, 16'h0);
    shutdown_n = 1; #1;
    chk("R10 before edge", {10'h0, pin_oe}, 16'h0);
    tick();
    chk("R10 released out", {10'h0, pin_out}, {10'h0, port_dout});
    chk("R10 released oe", {10'h0, pin_oe}, {10'h0, port_dir});

    finish_run();
  end
endmodule